// File: doc/BRIEF.md
# Translation Buffer Demap Controller

This block removes translations from a 64-entry translation buffer when software posts a demap request. The request carries an address. Bit 6 of that address picks the operation: demap one page or demap a whole context. Bits 5:4 pick which context value the operation uses. The controller keeps its own copy of every entry's tag, valid flag, global flag and page-size field. After it accepts a request it visits the entries one per clock and clears the valid flag of each entry that matches. When the whole buffer has been visited it pulses a done flag.

The primary and secondary context values come in from outside as plain inputs. They are captured at the moment the request is accepted. A tag holds the virtual page address in its upper bits and the 13-bit context number in its low 13 bits.

A simple write port loads entries and a combinational read port shows any entry. These two ports exist so that a surrounding buffer, or a bench, can fill the store and inspect it. Lookup and replacement are not part of this block.

Top module: `tlb_demap_ctrl`

## Requirements
- R1: After reset every entry is invalid, and busy and done are both low.
- R2: A request with address bit 6 set (context demap) clears every valid, non-global entry whose tag bits 12:0 equal the selected context.
- R3: A context demap never clears an entry whose global flag is set, even when its tag context equals the selected context.
- R4: Address bits 5:4 choose the context. The value 0 takes `prim_ctx`, 1 takes `sec_ctx` and 2 takes the constant 0. The chosen value is the one present in the cycle the request is accepted.
- R5: A request with bits 5:4 equal to 3 clears no entry. It still runs a full scan and still pulses done.
- R6: A request with address bit 6 clear (page demap) compares the address with the tag under a mask. The mask is all ones with its low 13+3*size bits cleared, where size is the entry's 2-bit size field. So size 0 spans 8 KiB, size 1 spans 64 KiB, size 2 spans 512 KiB and size 3 spans 4 MiB.
- R7: A page demap clears an entry whose page address matches only if that entry is global or its tag context equals the selected context.
- R8: Every request examines all 64 entries, and all matching entries are cleared, not only the first.
- R9: A request is accepted on a rising edge where `req_valid` is high and `busy` is low. `busy` is high from the next cycle. Entry k is examined in the k-th busy cycle. `done` is high for exactly one cycle, 64 cycles after the accept edge, and `busy` is low in that cycle.
- R10: A request presented while `busy` is high is ignored. It neither changes the scan in progress nor starts a second one.
- R11: Clearing an entry resets only its valid flag. The tag, global flag and size are kept.
- R12: If the write port loads an entry on the same edge that the scan clears that entry, the load wins and the entry holds the written contents and valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Demap request strobe |
| req_addr | input | 64 | Demap address: bit 6 operation, bits 5:4 context selector, upper bits page address |
| prim_ctx | input | 13 | Primary context value |
| sec_ctx | input | 13 | Secondary context value |
| wr_en | input | 1 | Entry load strobe |
| wr_idx | input | 6 | Entry index to load |
| wr_valid | input | 1 | Valid flag to load |
| wr_global | input | 1 | Global flag to load |
| wr_size | input | 2 | Page size field to load |
| wr_tag | input | 64 | Tag to load (page address plus context in bits 12:0) |
| rd_idx | input | 6 | Entry index to inspect |
| rd_valid | output | 1 | Valid flag of the inspected entry |
| rd_global | output | 1 | Global flag of the inspected entry |
| rd_size | output | 2 | Size field of the inspected entry |
| rd_tag | output | 64 | Tag of the inspected entry |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse when a scan finishes |

## Verification
Two functions can act on the same entry in the same cycle: a load through the write port and a clear by the scan. The bench provokes this by starting a context demap that matches entry 45. It then times a load of entry 45 so that it lands on the edge where the scan examines that index. Afterwards it reads entry 45 back and expects the loaded contents to be valid, while the other matching entries must be cleared. The second overlap is a request that arrives during a scan. The bench judges it by when done arrives, by whether a second done appears, and by the final valid flags.

// File: rtl/demap_pkg.sv
package demap_pkg;
  // Context selector codes carried in the request address.
  typedef enum logic [1:0] {
    SEL_PRIM = 2'd0,
    SEL_SEC  = 2'd1,
    SEL_NUC  = 2'd2,
    SEL_RSVD = 2'd3
  } ctx_sel_e;

  localparam int OP_BIT      = 6;   // 1 = context demap, 0 = page demap
  localparam int SEL_LSB     = 4;   // selector lives in bits SEL_LSB+1:SEL_LSB
  localparam int BASE_SHIFT  = 13;  // smallest page offset width
  localparam int SIZE_STEP   = 3;   // offset grows by this per size step
endpackage

// File: rtl/demap_decode.sv
module demap_decode #(
  parameter int CTX_W = 13
) (
  input  logic [2:0]       addr_bits,   // address bits 6:4
  input  logic [CTX_W-1:0] prim_ctx,
  input  logic [CTX_W-1:0] sec_ctx,
  output logic             op_is_ctx,
  output logic             sel_rsvd,
  output logic [CTX_W-1:0] sel_ctx
);
  import demap_pkg::*;

  ctx_sel_e sel;

  assign sel       = ctx_sel_e'(addr_bits[1:0]);
  assign op_is_ctx = addr_bits[2];

  always_comb begin
    sel_rsvd = 1'b0;
    sel_ctx  = '0;
    unique case (sel)
      SEL_PRIM: sel_ctx = prim_ctx;
      SEL_SEC:  sel_ctx = sec_ctx;
      SEL_NUC:  sel_ctx = '0;
      SEL_RSVD: sel_rsvd = 1'b1;
      default:  sel_rsvd = 1'b1;
    endcase
  end
endmodule

// File: rtl/demap_scan.sv
module demap_scan #(
  parameter int N_ENTRY = 64,
  localparam int IDX_W = $clog2(N_ENTRY)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             accept,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             last,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRY - 1);

  assign accept = req_valid && !busy;
  assign last   = busy && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (done && !busy));
  // R10
  busy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && idx == IDX_W'($past(idx) + 1'b1)));
endmodule

// File: rtl/demap_store.sv
module demap_store #(
  parameter int N_ENTRY = 64,
  parameter int VA_W    = 64,
  parameter int SIZE_W  = 2,
  localparam int IDX_W = $clog2(N_ENTRY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic              wr_global,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [VA_W-1:0]   wr_tag,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  output logic              sc_valid,
  output logic              sc_global,
  output logic [SIZE_W-1:0] sc_size,
  output logic [VA_W-1:0]   sc_tag,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_global,
  output logic [SIZE_W-1:0] rd_size,
  output logic [VA_W-1:0]   rd_tag
);
  logic [N_ENTRY-1:0] valid_q;
  logic [N_ENTRY-1:0] global_q;
  logic [SIZE_W-1:0]  size_q [N_ENTRY];
  logic [VA_W-1:0]    tag_q  [N_ENTRY];

  // Clear first, load second: a same-edge load overrides the clear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      if (clr_en) valid_q[clr_idx] <= 1'b0;
      if (wr_en)  valid_q[wr_idx]  <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      global_q[wr_idx] <= wr_global;
      size_q[wr_idx]   <= wr_size;
      tag_q[wr_idx]    <= wr_tag;
    end
  end

  assign sc_valid  = valid_q[clr_idx];
  assign sc_global = global_q[clr_idx];
  assign sc_size   = size_q[clr_idx];
  assign sc_tag    = tag_q[clr_idx];

  assign rd_valid  = valid_q[rd_idx];
  assign rd_global = global_q[rd_idx];
  assign rd_size   = size_q[rd_idx];
  assign rd_tag    = tag_q[rd_idx];

  // R11
  tag_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !wr_en) |=> (tag_q[$past(clr_idx)] == $past(sc_tag)));
  // R12
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && wr_en && wr_idx == clr_idx) |=> (valid_q[$past(clr_idx)] == $past(wr_valid)));
endmodule

// File: rtl/demap_match.sv
module demap_match #(
  parameter int VA_W   = 64,
  parameter int CTX_W  = 13,
  parameter int SIZE_W = 2
) (
  input  logic              e_valid,
  input  logic              e_global,
  input  logic [SIZE_W-1:0] e_size,
  input  logic [VA_W-1:0]   e_tag,
  input  logic [VA_W-1:0]   q_addr,
  input  logic [CTX_W-1:0]  q_ctx,
  input  logic              q_op_ctx,
  input  logic              q_rsvd,
  output logic              hit
);
  import demap_pkg::*;

  function automatic logic [VA_W-1:0] page_mask(input logic [SIZE_W-1:0] sz);
    logic [VA_W-1:0] m;
    m = '1;
    return m << (BASE_SHIFT + SIZE_STEP * int'(sz));
  endfunction

  function automatic logic page_hit(input logic [VA_W-1:0] a,
                                    input logic [VA_W-1:0] t,
                                    input logic [SIZE_W-1:0] sz);
    return ((a ^ t) & page_mask(sz)) == '0;
  endfunction

  logic ctx_eq;
  assign ctx_eq = (e_tag[CTX_W-1:0] == q_ctx);

  always_comb begin
    if (!e_valid || q_rsvd)
      hit = 1'b0;
    else if (q_op_ctx)
      hit = !e_global && ctx_eq;
    else
      hit = page_hit(q_addr, e_tag, e_size) && (e_global || ctx_eq);
  end
endmodule

// File: rtl/tlb_demap_ctrl.sv
module tlb_demap_ctrl #(
  parameter int N_ENTRY = 64,
  parameter int VA_W    = 64,
  parameter int CTX_W   = 13,
  parameter int SIZE_W  = 2,
  localparam int IDX_W = $clog2(N_ENTRY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_addr,
  input  logic [CTX_W-1:0]  prim_ctx,
  input  logic [CTX_W-1:0]  sec_ctx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic              wr_global,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [VA_W-1:0]   wr_tag,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_global,
  output logic [SIZE_W-1:0] rd_size,
  output logic [VA_W-1:0]   rd_tag,
  output logic              busy,
  output logic              done
);
  import demap_pkg::*;

  // Decoded view of the incoming request.
  logic             dec_op_ctx;
  logic             dec_rsvd;
  logic [CTX_W-1:0] dec_ctx;

  // Request captured at accept time.
  logic [VA_W-1:0]  addr_q;
  logic             op_q;
  logic             rsvd_q;
  logic [CTX_W-1:0] ctx_q;

  // Scan and store events, named for the assertions.
  logic             accept;
  logic             last;
  logic [IDX_W-1:0] scan_idx;
  logic             sc_valid;
  logic             sc_global;
  logic [SIZE_W-1:0] sc_size;
  logic [VA_W-1:0]  sc_tag;
  logic             entry_hit;
  logic             clr_fire;

  demap_decode #(.CTX_W(CTX_W)) u_decode (
    .addr_bits (req_addr[OP_BIT:SEL_LSB]),
    .prim_ctx  (prim_ctx),
    .sec_ctx   (sec_ctx),
    .op_is_ctx (dec_op_ctx),
    .sel_rsvd  (dec_rsvd),
    .sel_ctx   (dec_ctx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      op_q   <= 1'b0;
      rsvd_q <= 1'b1;
      ctx_q  <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      op_q   <= dec_op_ctx;
      rsvd_q <= dec_rsvd;
      ctx_q  <= dec_ctx;
    end
  end

  demap_scan #(.N_ENTRY(N_ENTRY)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .accept    (accept),
    .busy      (busy),
    .idx       (scan_idx),
    .last      (last),
    .done      (done)
  );

  demap_store #(.N_ENTRY(N_ENTRY), .VA_W(VA_W), .SIZE_W(SIZE_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_valid  (wr_valid),
    .wr_global (wr_global),
    .wr_size   (wr_size),
    .wr_tag    (wr_tag),
    .clr_en    (clr_fire),
    .clr_idx   (scan_idx),
    .sc_valid  (sc_valid),
    .sc_global (sc_global),
    .sc_size   (sc_size),
    .sc_tag    (sc_tag),
    .rd_idx    (rd_idx),
    .rd_valid  (rd_valid),
    .rd_global (rd_global),
    .rd_size   (rd_size),
    .rd_tag    (rd_tag)
  );

  demap_match #(.VA_W(VA_W), .CTX_W(CTX_W), .SIZE_W(SIZE_W)) u_match (
    .e_valid  (sc_valid),
    .e_global (sc_global),
    .e_size   (sc_size),
    .e_tag    (sc_tag),
    .q_addr   (addr_q),
    .q_ctx    (ctx_q),
    .q_op_ctx (op_q),
    .q_rsvd   (rsvd_q),
    .hit      (entry_hit)
  );

  assign clr_fire = busy && entry_hit;

  // R2
  clear_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |-> sc_valid);
  // R3
  global_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fire && op_q) |-> !sc_global);
  // R5
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rsvd_q) |-> !clr_fire);
  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(addr_q));
endmodule

// File: tb/tlb_demap_ctrl_bench.sv
module tlb_demap_ctrl_bench;
  localparam int VA_W = 64;
  localparam int CTX_W = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [VA_W-1:0] req_addr = '0;
  logic [CTX_W-1:0] prim_ctx = '0, sec_ctx = '0;
  logic wr_en = 1'b0, wr_valid = 1'b0, wr_global = 1'b0;
  logic [5:0] wr_idx = '0, rd_idx = '0;
  logic [1:0] wr_size = '0;
  logic [VA_W-1:0] wr_tag = '0;
  logic rd_valid, rd_global, busy, done;
  logic [1:0] rd_size;
  logic [VA_W-1:0] rd_tag;

  always #10 clk = ~clk;

  tlb_demap_ctrl u_tlb_demap_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .prim_ctx(prim_ctx), .sec_ctx(sec_ctx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_valid(wr_valid), .wr_global(wr_global), .wr_size(wr_size), .wr_tag(wr_tag),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_global(rd_global), .rd_size(rd_size),
    .rd_tag(rd_tag), .busy(busy), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Preloaded entry set: index, tag (page | context), global, size.
  localparam int unsigned E_IDX [8] = '{0, 1, 5, 17, 30, 45, 62, 63};
  localparam logic [31:0] E_TAG [8] = '{32'h0040_0005, 32'h0040_2005, 32'h0040_0009,
                                        32'h0040_0003, 32'h0080_0000, 32'h0100_0005,
                                        32'h0200_0009, 32'h0300_0007};
  localparam logic [7:0] E_GLB = 8'b0000_1000;
  localparam logic [1:0] E_SZ [8] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd3, 2'd2};

  // Vector: op[68] sel[67:66] va[65:34] prim[33:21] sec[20:8] expected valid mask[7:0]
  localparam int NV = 14;
  localparam logic [68:0] VEC [NV] = '{
    {1'b1, 2'd0, 32'h0000_0000, 13'd5, 13'd9, 8'hDC},
    {1'b1, 2'd1, 32'h0000_0000, 13'd5, 13'd9, 8'hBB},
    {1'b1, 2'd2, 32'h0000_0000, 13'd5, 13'd9, 8'hEF},
    {1'b1, 2'd3, 32'h0000_0000, 13'd5, 13'd9, 8'hFF},
    {1'b1, 2'd0, 32'h0000_0000, 13'd3, 13'd9, 8'hFF},
    {1'b0, 2'd0, 32'h0040_0000, 13'd5, 13'd9, 8'hF6},
    {1'b0, 2'd1, 32'h0040_0000, 13'd5, 13'd9, 8'hF3},
    {1'b0, 2'd0, 32'h0100_8000, 13'd5, 13'd9, 8'hDF},
    {1'b0, 2'd1, 32'h023F_E000, 13'd5, 13'd9, 8'hBF},
    {1'b0, 2'd0, 32'h0307_0000, 13'd7, 13'd9, 8'h7F},
    {1'b0, 2'd0, 32'h0308_0000, 13'd7, 13'd9, 8'hFF},
    {1'b0, 2'd2, 32'h0080_0000, 13'd5, 13'd9, 8'hEF},
    {1'b0, 2'd3, 32'h0040_0000, 13'd5, 13'd9, 8'hFF},
    {1'b0, 2'd0, 32'h0040_0000, 13'd8, 13'd9, 8'hF7}
  };

  function automatic string row_req(input int r);
    case (r)
      0: return "R2/R8 ctx-primary";
      1: return "R2/R4 ctx-secondary";
      2: return "R3/R4 ctx-nucleus";
      3: return "R5 ctx-reserved";
      4: return "R3 ctx-global-kept";
      5, 6: return "R7/R4 page-ctx-or-global";
      7, 8, 9: return "R6 page-size-mask";
      10: return "R6 page-mask-edge";
      11: return "R4 page-nucleus";
      12: return "R5 page-reserved";
      default: return "R7 page-global-only";
    endcase
  endfunction

  task automatic write_entry(input int idx, input logic [63:0] tag,
                             input logic g, input logic [1:0] sz, input logic v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_tag = tag;
    wr_global = g; wr_size = sz; wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_set();
    for (int e = 0; e < 8; e++)
      write_entry(int'(E_IDX[e]), 64'(E_TAG[e]), E_GLB[e], E_SZ[e], 1'b1);
  endtask

  // Ends at the first falling edge after the accept edge.
  task automatic start_req(input logic op, input logic [1:0] sel, input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = 64'(va) | (64'(op) << 6) | (64'(sel) << 4);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic read_mask(output logic [7:0] m, output bit tags_ok);
    tags_ok = 1'b1;
    for (int e = 0; e < 8; e++) begin
      rd_idx = 6'(E_IDX[e]);
      #1;
      m[e] = rd_valid;
      if (rd_tag != 64'(E_TAG[e]) || rd_global != E_GLB[e] || rd_size != E_SZ[e])
        tags_ok = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cyc;
    int nvalid;
    logic [7:0] m;
    bit tok;
    bit extra_done;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    nvalid = 0;
    for (int i = 0; i < 64; i++) begin
      rd_idx = 6'(i);
      #1;
      if (rd_valid) nvalid++;
    end
    chk(nvalid == 0, "R1", "valid entries after reset", 64'(nvalid), 64'd0);
    chk(!busy && !done, "R1", "busy/done after reset", {62'd0, busy, done}, 64'd0);

    // Vector walk
    for (int r = 0; r < NV; r++) begin
      prim_ctx = VEC[r][33:21];
      sec_ctx  = VEC[r][20:8];
      load_set();
      start_req(VEC[r][68], VEC[r][67:66], VEC[r][65:34]);
      wait_done(cyc);
      read_mask(m, tok);
      chk(m == VEC[r][7:0], row_req(r), $sformatf("row %0d valid mask", r),
          64'(m), 64'(VEC[r][7:0]));
      chk(tok, "R11", $sformatf("row %0d tag/global/size kept", r), 64'(tok), 64'd1);
    end

    // R9: timing of busy and done
    prim_ctx = 13'd5;
    load_set();
    start_req(1'b1, 2'd0, 32'h0);
    chk(busy == 1'b1, "R9", "busy after accept", 64'(busy), 64'd1);
    wait_done(cyc);
    chk(cyc == 64, "R9", "cycles to done", 64'(cyc), 64'd64);
    chk(!busy, "R9", "busy during done", 64'(busy), 64'd0);
    @(negedge clk);
    chk(!done, "R9", "done width", 64'(done), 64'd0);

    // R10: request while busy is ignored
    load_set();
    start_req(1'b1, 2'd3, 32'h0);
    repeat (9) @(negedge clk);
    req_valid = 1'b1;
    req_addr = (64'd1 << 6);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(cyc);
    chk(cyc == 54, "R10", "done time unchanged", 64'(cyc), 64'd54);
    read_mask(m, tok);
    chk(m == 8'hFF, "R10", "late request had no effect", 64'(m), 64'hFF);
    extra_done = 1'b0;
    repeat (80) begin
      @(negedge clk);
      if (done || busy) extra_done = 1'b1;
    end
    chk(!extra_done, "R10", "no second scan", 64'(extra_done), 64'd0);

    // R12: load and clear of entry 45 on the same edge
    prim_ctx = 13'd5;
    load_set();
    start_req(1'b1, 2'd0, 32'h0);
    repeat (45) @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd45; wr_tag = 64'h0100_0005;
    wr_global = 1'b0; wr_size = 2'd1; wr_valid = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    wait_done(cyc);
    read_mask(m, tok);
    chk(m == 8'hFC, "R12", "load wins over clear", 64'(m), 64'hFC);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule